// File: doc/BRIEF.md
# Split-Register Serial Port Slave

This block is a memory-mapped serial port for a small processor. It sits on a valid/ready request/response bus and offers three word registers. A write to the transmit register sends one byte as an asynchronous 8N1 frame. A read of the receive register takes the oldest byte out of a 16-entry receive queue. A status register shows whether the transmitter is busy and whether received data is waiting.

The register layout is a custom split layout and is not 16550-compatible. Reading the receive register has a side effect: it removes a byte. Firmware polls status before each transmit write, because a transmit write made during a frame is dropped. The bit time is fixed by a parameter, given as a number of clock cycles per bit.

Top module: `uart_split_mmio`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1, uart_txd is high and a status read returns 0.
- R2: A request is accepted on a cycle with req_valid and req_ready both high. rsp_valid rises on the next cycle and holds, with rsp_rdata and rsp_err stable, until rsp_ready is seen. req_ready is low while a response is pending.
- R3: A write to offset 0x0 while the transmitter is idle sends wdata bits 7:0 on uart_txd. The frame is a low start bit, then eight data bits LSB first, then a high stop bit, each CLKS_PER_BIT cycles long. The line goes low in the cycle after acceptance, and uart_txd stays high whenever the transmitter is idle.
- R4: A write to offset 0x0 while tx_busy is 1 is dropped without error, and the frame in progress is unchanged.
- R5: A read of offset 0x8 returns tx_busy in bit 0 and rx_valid (queue not empty) in bit 1, with all other bits 0. tx_busy is 1 from transmit acceptance to the end of the stop bit.
- R6: uart_rxd passes through a two-flop synchroniser and is sampled at mid-bit. Each valid 8N1 frame is queued. A read of offset 0x4 returns the oldest byte in bits 7:0, with bits 31:8 zero, and removes it.
- R7: A read of offset 0x4 with an empty queue returns 0 with rsp_err 0 and removes nothing.
- R8: The receive queue holds 16 bytes. A byte that completes while the queue is full is discarded, and the 16 oldest bytes are kept in order.
- R9: A frame whose stop bit samples low is discarded. The receiver rearms only after the line has returned high, and the next good frame is received.
- R10: Only address bits 11:0 are decoded. A write to 0x4 or 0x8, or any access to another offset, gets rsp_err 1 with rdata 0 and has no side effect. A read of 0x0 returns 0 without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slave can accept a request |
| req_addr | input | 32 | Byte address; bits 11:0 select the register |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size (ignored) |
| req_wdata | input | 32 | Write data; bits 7:0 used |
| req_wstrb | input | 4 | Byte enables (ignored) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access error |
| uart_txd | output | 1 | Serial transmit line, idle high |
| uart_rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The assertions check the bus timing on every cycle: a response follows each accepted request, and it is held stable under back-pressure. They also check that the line idles high and that each frame opens with a low start bit. Further cycle checks cover: queue occupancy does not change on a push while full or a pop while empty, a queued byte always had a high stop sample, writes to the receive register fail, and a dropped transmit write leaves the transmitter busy. Some behaviour shows only in the bench scenarios, which decode the serial output independently and drive serial frames in: byte values and bit order on the line, first-in first-out order across a full queue, which byte is lost on overflow, recovery after a bad stop bit, and the data returned by each register.

// File: rtl/uart_mmio_pkg.sv
`timescale 1ns/1ps
// Shared types for the split-register serial port.
// Assumes register offsets are word aligned and fit in a 12-bit window.
package uart_mmio_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        REG_TX   = 2'd0,
        REG_RX   = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_HOLD  = 3'd4
    } rx_state_e;

    // Map a zero-extended window offset onto a register selector.
    function automatic reg_sel_e decode_reg(input logic [BUS_W-1:0] off);
        case (off)
            32'h0:   return REG_TX;
            32'h4:   return REG_RX;
            32'h8:   return REG_STAT;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
// 8N1 serial transmitter.
// Loads a byte when start_i is high while idle and shifts it out LSB first.
// Assumes CLKS_PER_BIT >= 4; a start request while busy is ignored.
module uart_tx
    import uart_mmio_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    output logic       busy_o,
    output logic       txd_o
);
    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    tx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    idx_q;
    logic [7:0]    shreg_q;
    logic          txd_q;

    // Frame sequencer: start bit, eight data bits, stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            txd_q   <= 1'b1;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (start_i) begin
                        state_q <= TX_START;
                        shreg_q <= data_i;
                        cnt_q   <= '0;
                        txd_q   <= 1'b0;
                    end
                end
                TX_START: begin
                    if (cnt_q == LAST) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= TX_DATA;
                        txd_q   <= shreg_q[0];
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_DATA: begin
                    if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        if (idx_q == 3'd7) begin
                            state_q <= TX_STOP;
                            txd_q   <= 1'b1;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            shreg_q <= shreg_q >> 1;
                            txd_q   <= shreg_q[1];
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == LAST) begin
                        state_q <= TX_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy_o = (state_q != TX_IDLE);
    assign txd_o  = txd_q;

    // R3: line is high whenever no frame is in progress.
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> txd_o);

    // R3: each frame opens with a low start bit.
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !txd_o);

endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
// 8N1 serial receiver.
// Synchronises rxd through two flops, checks the start bit at mid-bit, and
// samples each data bit and the stop bit at mid-bit. A good frame pulses
// valid_o for one cycle. After a low stop bit it waits for a high line.
// Assumes CLKS_PER_BIT >= 4.
module uart_rx
    import uart_mmio_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    output logic       valid_o,
    output logic [7:0] data_o
);
    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

    logic          meta_q, sync_q;
    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    idx_q;
    logic [7:0]    shreg_q;
    logic          valid_q;
    logic [7:0]    data_q;

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= rxd_i;
            sync_q <= meta_q;
        end
    end

    // Frame sampler: start check, data shift, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (!sync_q) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt_q == HALF) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= sync_q ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == LAST) begin
                        cnt_q   <= '0;
                        shreg_q <= {sync_q, shreg_q[7:1]};
                        if (idx_q == 3'd7) begin
                            state_q <= RX_STOP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        if (sync_q) begin
                            valid_q <= 1'b1;
                            data_q  <= shreg_q;
                            state_q <= RX_IDLE;
                        end else begin
                            state_q <= RX_HOLD;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (sync_q) begin
                        state_q <= RX_IDLE;
                    end
                end
            endcase
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

    // R9: a byte is only delivered when its stop sample was high.
    a_r9_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(sync_q));

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
// Byte queue for received data.
// A push while full and a pop while empty are ignored. The head byte is
// visible on head_o whenever empty_o is low. DEPTH must be a power of two.
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem_q [DEPTH];
    logic [AW:0]  wptr_q, rptr_q;
    logic [AW:0]  level;
    logic         do_push, do_pop;

    assign level   = wptr_q - rptr_q;
    assign empty_o = (wptr_q == rptr_q);
    assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem_q[rptr_q[AW-1:0]];

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wptr_q[AW-1:0]] <= data_i;
        end
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
        end
    end

    // R8: a push while full does not change occupancy.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> $stable(level));

    // R7: a pop while empty does not change occupancy.
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> $stable(level));

endmodule

// File: rtl/uart_split_mmio.sv
`timescale 1ns/1ps
// Bus slave with three word registers: transmit (0x0), receive (0x4),
// status (0x8). A request is accepted when no response is pending and is
// answered one cycle later. Side effects (transmit start, receive pop)
// take place at acceptance. Address bits above the window and the size and
// strobe fields are ignored; region decode is done upstream.
module uart_split_mmio
    import uart_mmio_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434,
    parameter int RX_DEPTH     = 16,
    parameter int WIN_W        = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        req_we,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_wstrb,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        uart_txd,
    input  logic        uart_rxd
);
    reg_sel_e   sel;
    logic       accept;
    logic       tx_start, tx_busy;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic [7:0] fifo_head;
    logic       fifo_empty, fifo_full, fifo_pop;
    logic [BUS_W-1:0] rd_next;
    logic       err_next;
    logic       rsp_valid_q, rsp_err_q;
    logic [BUS_W-1:0] rsp_rdata_q;
    logic       unused_bits;

    assign unused_bits = ^{req_size, req_wstrb, req_addr[31:WIN_W], req_wdata[31:8], fifo_full};

    assign sel       = decode_reg({{(BUS_W-WIN_W){1'b0}}, req_addr[WIN_W-1:0]});
    assign req_ready = !rsp_valid_q;
    assign accept    = req_valid && req_ready;
    assign tx_start  = accept && req_we && (sel == REG_TX) && !tx_busy;
    assign fifo_pop  = accept && !req_we && (sel == REG_RX) && !fifo_empty;

    // Read data and error for the request being accepted.
    always_comb begin
        rd_next  = '0;
        err_next = 1'b0;
        case (sel)
            REG_TX: ;
            REG_RX: begin
                if (req_we)           err_next = 1'b1;
                else if (!fifo_empty) rd_next  = {{(BUS_W-8){1'b0}}, fifo_head};
            end
            REG_STAT: begin
                if (req_we) err_next = 1'b1;
                else        rd_next  = {{(BUS_W-2){1'b0}}, !fifo_empty, tx_busy};
            end
            default: err_next = 1'b1;
        endcase
    end

    // Response register: load on accept, clear on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else if (accept) begin
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= err_next;
            rsp_rdata_q <= rd_next;
        end else if (rsp_ready) begin
            rsp_valid_q <= 1'b0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;
    assign rsp_err   = rsp_err_q;

    uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .data_i  (req_wdata[7:0]),
        .busy_o  (tx_busy),
        .txd_o   (uart_txd)
    );

    uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_i   (uart_rxd),
        .valid_o (rx_valid),
        .data_o  (rx_byte)
    );

    uart_rx_fifo #(.DEPTH(RX_DEPTH), .W(8)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_valid),
        .data_i  (rx_byte),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    // R2: every accepted request gets a response on the next cycle.
    a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R2: a stalled response holds its payload.
    a_r2_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

    // R10: a write to the receive register always reports an error.
    a_r10_rx_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_we && req_addr[WIN_W-1:0] == WIN_W'(4)) |=> rsp_err);

    // R4: a transmit write during a frame is not an error and keeps the frame going.
    a_r4_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_we && req_addr[WIN_W-1:0] == '0 && tx_busy)
        |=> (tx_busy && !rsp_err));

endmodule

// File: tb/test_uart_split_mmio.sv
`timescale 1ns/1ps
module test_uart_split_mmio;
    localparam int C = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_wstrb = 4'hF;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        uart_txd;
    logic        uart_rxd = 1'b1;

    int checks = 0;
    int fails = 0;
    logic [7:0] cap [0:63];
    int cap_n = 0;
    int cap_bad = 0;

    always #5 clk = ~clk;

    uart_split_mmio #(.CLKS_PER_BIT(C), .RX_DEPTH(16), .WIN_W(12)) i_uart_split_mmio (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_size(req_size), .req_wdata(req_wdata),
        .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .uart_txd(uart_txd), .uart_rxd(uart_rxd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus access; returns at the negedge after acceptance.
    task automatic bus(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd, output logic err);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rsp_valid one cycle after accept", 32'(rsp_valid), 32'd1);
        rd = rsp_rdata;
        err = rsp_err;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk);
        uart_rxd = 1'b0;
        repeat (C) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            uart_rxd = b[i];
            repeat (C) @(negedge clk);
        end
        uart_rxd = stop;
        repeat (C) @(negedge clk);
        uart_rxd = 1'b1;
        repeat (2*C) @(negedge clk);
    endtask

    // Independent decoder of the transmit line.
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && uart_txd === 1'b0) begin
                repeat (C/2) @(negedge clk);
                if (uart_txd !== 1'b0) cap_bad++;
                for (int i = 0; i < 8; i++) begin
                    repeat (C) @(negedge clk);
                    b[i] = uart_txd;
                end
                repeat (C) @(negedge clk);
                if (uart_txd !== 1'b1) cap_bad++;
                cap[cap_n] = b;
                cap_n++;
            end
        end
    end

    task automatic t_reset();
        logic [31:0] rd; logic err;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk("R1 txd idle high", 32'(uart_txd), 32'd1);
        bus(1'b0, 32'h8, 0, rd, err);
        chk("R1 status after reset", rd, 32'd0);
    endtask

    task automatic t_tx_frame();
        logic [31:0] rd; logic err; int n0;
        n0 = cap_n;
        bus(1'b1, 32'h0, 32'h1C5, rd, err);
        chk("R3 tx write no err", 32'(err), 32'd0);
        chk("R3 line low after accept", 32'(uart_txd), 32'd0);
        bus(1'b0, 32'h8, 0, rd, err);
        chk("R5 status busy during frame", rd, 32'h1);
        repeat (10*C + 4) @(negedge clk);
        chk("R3 one byte sent", 32'(cap_n - n0), 32'd1);
        chk("R3 byte value LSB first", 32'(cap[n0]), 32'hC5);
        chk("R3 framing", 32'(cap_bad), 32'd0);
        bus(1'b0, 32'h8, 0, rd, err);
        chk("R5 status idle after frame", rd, 32'h0);
    endtask

    task automatic t_tx_busy_drop();
        logic [31:0] rd; logic err; int n0;
        n0 = cap_n;
        bus(1'b1, 32'h0, 32'h5A, rd, err);
        bus(1'b1, 32'h0, 32'h77, rd, err);
        chk("R4 dropped write no err", 32'(err), 32'd0);
        repeat (12*C) @(negedge clk);
        chk("R4 only first byte sent", 32'(cap_n - n0), 32'd1);
        chk("R4 frame unchanged", 32'(cap[n0]), 32'h5A);
        bus(1'b1, 32'h0, 32'h81, rd, err);
        repeat (11*C) @(negedge clk);
        chk("R3 next write after idle", 32'(cap[n0+1]), 32'h81);
        chk("R3 framing", 32'(cap_bad), 32'd0);
    endtask

    task automatic t_rx_basic();
        logic [31:0] rd; logic err;
        send_rx(8'h12, 1'b1);
        send_rx(8'hF0, 1'b1);
        bus(1'b0, 32'h8, 0, rd, err);
        chk("R5 status rx_valid", rd, 32'h2);
        bus(1'b0, 32'h4, 0, rd, err);
        chk("R6 first byte", rd, 32'h12);
        chk("R6 no err", 32'(err), 32'd0);
        bus(1'b0, 32'h4, 0, rd, err);
        chk("R6 second byte", rd, 32'hF0);
        bus(1'b0, 32'h8, 0, rd, err);
        chk("R6 queue drained", rd, 32'h0);
    endtask

    task automatic t_rx_empty();
        logic [31:0] rd; logic err;
        bus(1'b0, 32'h4, 0, rd, err);
        chk("R7 empty read data", rd, 32'h0);
        chk("R7 empty read no err", 32'(err), 32'd0);
        send_rx(8'h99, 1'b1);
        bus(1'b0, 32'h4, 0, rd, err);
        chk("R7 no phantom pop", rd, 32'h99);
    endtask

    task automatic t_rx_overflow();
        logic [31:0] rd; logic err;
        for (int i = 0; i < 17; i++) send_rx(8'(i*7 + 1), 1'b1);
        for (int i = 0; i < 16; i++) begin
            bus(1'b0, 32'h4, 0, rd, err);
            chk("R8 order across full queue", rd, 32'(8'(i*7 + 1)));
        end
        bus(1'b0, 32'h4, 0, rd, err);
        chk("R8 seventeenth byte discarded", rd, 32'h0);
    endtask

    task automatic t_bad_stop();
        logic [31:0] rd; logic err;
        send_rx(8'h33, 1'b0);
        bus(1'b0, 32'h8, 0, rd, err);
        chk("R9 bad frame not queued", rd, 32'h0);
        send_rx(8'h44, 1'b1);
        bus(1'b0, 32'h4, 0, rd, err);
        chk("R9 next good frame", rd, 32'h44);
    endtask

    task automatic t_errors();
        logic [31:0] rd; logic err;
        send_rx(8'h6B, 1'b1);
        bus(1'b1, 32'h4, 32'hFF, rd, err);
        chk("R10 write rx err", 32'(err), 32'd1);
        chk("R10 write rx data", rd, 32'h0);
        bus(1'b1, 32'h8, 32'hFF, rd, err);
        chk("R10 write status err", 32'(err), 32'd1);
        bus(1'b0, 32'hC, 0, rd, err);
        chk("R10 read 0xC err", 32'(err), 32'd1);
        bus(1'b0, 32'h100, 0, rd, err);
        chk("R10 read 0x100 err", 32'(err), 32'd1);
        bus(1'b0, 32'h0, 0, rd, err);
        chk("R10 read tx no err", 32'(err), 32'd0);
        chk("R10 read tx data", rd, 32'h0);
        bus(1'b0, 32'h1004, 0, rd, err);
        chk("R10 upper bits ignored, no pop by err", rd, 32'h6B);
        chk("R10 rx read no err", 32'(err), 32'd0);
    endtask

    task automatic t_resp_hold();
        logic [31:0] v0;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_we = 1'b0; req_addr = 32'h8;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 response raised", 32'(rsp_valid), 32'd1);
        v0 = rsp_rdata;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 response held", 32'(rsp_valid), 32'd1);
            chk("R2 ready low while pending", 32'(req_ready), 32'd0);
            chk("R2 data stable", rsp_rdata, v0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R2 response released", 32'(rsp_valid), 32'd0);
        chk("R2 ready restored", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_frame();
        t_tx_busy_drop();
        t_rx_basic();
        t_rx_empty();
        t_rx_overflow();
        t_bad_stop();
        t_errors();
        t_resp_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule